// File: doc/BRIEF.md
# Quad Latch Bank with Readback

The block holds four code registers that feed four converter channels. All four share one 8-bit input data port. Two active-low strobes, a member-select line and a direction line choose one latch or a pair of latches to load. They can also return the contents of one latch onto a shared bus, or leave every latch alone. The host sees an access that works like a static memory cycle: it sets up the address-like controls, pulses a strobe low, and either places a code on the bus or collects one from it. The channel outputs follow the bus while a write is in progress, which is the transparent behaviour of a latch. When the write ends they freeze on the last bus value.

The block runs from a system clock. The strobes and the two control lines pass through a two-flop synchronizer before they are decoded. Data is taken straight from the bus. The host must therefore keep the bus stable from its setup point until the strobe has been high for a few clocks. The return path appears as a data word plus an output enable, which drive an external tri-state pad.

Top module: `qlb_bank`

## Requirements
- R1: While reset is low, and after it is released, all four channel codes read 0x00, the bus enable is low and the returned word is 0x00.
- R2: With the direction line low (write), strobe `stb_ab_n` low selects latch 0 (A) when `half_sel` is 0 and latch 1 (B) when it is 1. Strobe `stb_cd_n` low selects latch 2 (C) when `half_sel` is 0 and latch 3 (D) when it is 1. Latch i drives `codes[8*i+7:8*i]`, and bit 0 of each code is its LSB.
- R3: While a write to a latch is active after synchronization, that latch's channel code equals `bus_in` in the same cycle, including when `bus_in` changes mid-write.
- R4: When a write ends, the latch keeps the bus value sampled on the last clock edge of the write. Later changes on `bus_in` do not alter it.
- R5: A write with both strobes low loads the same bus value into latches 0 and 2 when `half_sel` is 0, and into latches 1 and 3 when it is 1. The other two latches are unchanged.
- R6: A read (direction line high) with exactly one strobe low raises `bus_oe` and places the selected latch's code on `bus_out`. Latches are selected as in R2.
- R7: A read with both strobes low is invalid. `bus_oe` stays low and no latch changes.
- R8: With both strobes high, no latch changes and `bus_oe` is low, whatever the values on `half_sel`, `rd_mode` and `bus_in`.
- R9: A strobe edge takes effect only after SYNC_STAGES (default 2) rising clock edges. With the default, a write is not yet visible after one edge and is visible after two.
- R10: Whenever `bus_oe` is low, `bus_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_ab_n | input | 1 | Active-low strobe for latches A and B |
| stb_cd_n | input | 1 | Active-low strobe for latches C and D |
| half_sel | input | 1 | Picks the second latch of each strobe's pair when high |
| rd_mode | input | 1 | 1 = read back, 0 = write |
| bus_in | input | DATA_W | Data from the bus pad |
| bus_out | output | DATA_W | Returned latch code, zero when not driving |
| bus_oe | output | 1 | Enable for the bus pad's tri-state driver |
| codes | output | 4*DATA_W | Channel codes, latch i in bits 8*i+7 to 8*i |

## Verification
The assertions check on every cycle that an active write makes its channel code equal the bus (R3) and that a finished write leaves the last sampled value (R4). They also check that idle or invalid decodes never enable the bus driver and that codes stay stable without a write (R7, R8). Finally they check that a dual write never touches both members of one pair (R5) and that the returned word is zero while undriven (R10). Only the bench's scenarios can show the mapping from each strobe and member-select combination to a specific latch, and the synchronizer delay. The bench alone also shows the end-to-end agreement between written values and later reads, which it covers with a sweep of all 256 codes across the four latches.

// File: rtl/qlb_pkg.sv
package qlb_pkg;

  localparam int unsigned N_GROUPS  = 2;
  localparam int unsigned N_MEMBERS = 2;
  localparam int unsigned N_LATCH   = N_GROUPS * N_MEMBERS;
  localparam int unsigned IDX_W     = $clog2(N_LATCH);

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  // group 0 = strobe for A/B, group 1 = strobe for C/D; member picks second of pair
  function automatic logic [IDX_W-1:0] latch_index(input logic group, input logic member);
    return {group, member};
  endfunction

  // one bit per latch, set for every active group at the chosen member
  function automatic logic [N_LATCH-1:0] group_mask(input logic [N_GROUPS-1:0] grp_act,
                                                    input logic member);
    logic [N_LATCH-1:0] m;
    m = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (grp_act[g]) m[latch_index(g[0], member)] = 1'b1;
    end
    return m;
  endfunction

  function automatic acc_e classify(input logic [N_GROUPS-1:0] grp_act, input logic rd);
    if (grp_act == '0)            return ACC_IDLE;
    else if (!rd)                 return ACC_WRITE;
    else if ($countones(grp_act) == 1) return ACC_READ;
    else                          return ACC_BAD;
  endfunction

endpackage

// File: rtl/qlb_sync.sv
module qlb_sync #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/qlb_decode.sv
module qlb_decode
  import qlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb_ab_n,
  input  logic               stb_cd_n,
  input  logic               member,
  input  logic               rd,
  output logic [N_LATCH-1:0] wr_mask,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_idx,
  output acc_e               access
);

  logic [N_GROUPS-1:0] grp_act;
  logic                both_act;
  logic                none_act;

  assign grp_act  = {~stb_cd_n, ~stb_ab_n};
  assign both_act = &grp_act;
  assign none_act = ~|grp_act;
  assign access   = classify(grp_act, rd);

  assign wr_mask = (access == ACC_WRITE) ? group_mask(grp_act, member) : '0;
  assign rd_en   = (access == ACC_READ);
  assign rd_idx  = latch_index(grp_act[1], member);

  // R7: a dual read is never a valid read
  p_dual_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (both_act && rd) |-> !rd_en);

  // R8: no strobe means no write and no read
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    none_act |-> (wr_mask == '0 && !rd_en));

  // R5: a pair member never shares a write with its partner
  p_pair_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mask[0] && wr_mask[1]) && !(wr_mask[2] && wr_mask[3]));

endmodule

// File: rtl/qlb_cell.sv
module qlb_cell #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] code
);

  logic wr_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (wr_en) held <= d;
  end

  // transparent while the write decode is active
  assign code = wr_en ? d : held;

  // closing edge of a write, for the checks below
  logic wr_en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en_q <= 1'b0;
    else        wr_en_q <= wr_en;
  end
  assign wr_end = wr_en_q && !wr_en;

  // R4: after the write closes the output shows the last sampled bus value
  p_keep_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |-> code == $past(d));

  // R4: without a write the stored code does not move
  p_no_drift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_q |-> $stable(held));

endmodule

// File: rtl/qlb_readback.sv
module qlb_readback
  import qlb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LATCH*DATA_W-1:0] held_all,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [DATA_W-1:0]         bus_out,
  output logic                      bus_oe
);

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_LATCH; i++) begin
      if (rd_idx == IDX_W'(i)) picked = held_all[i*DATA_W +: DATA_W];
    end
  end

  assign bus_oe  = rd_en;
  assign bus_out = rd_en ? picked : '0;

  // R10: an undriven bus returns zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);

endmodule

// File: rtl/qlb_bank.sv
module qlb_bank
  import qlb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stb_ab_n,
  input  logic                      stb_cd_n,
  input  logic                      half_sel,
  input  logic                      rd_mode,
  input  logic [DATA_W-1:0]         bus_in,
  output logic [DATA_W-1:0]         bus_out,
  output logic                      bus_oe,
  output logic [N_LATCH*DATA_W-1:0] codes
);

  localparam int unsigned CTRL_W = 4;
  // strobes rest high, member and direction rest low
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0011;

  logic [CTRL_W-1:0]         ctrl_raw;
  logic [CTRL_W-1:0]         ctrl_s;
  logic                      s_ab_n, s_cd_n, s_member, s_rd;
  logic [N_LATCH-1:0]        wr_mask;
  logic                      rd_en;
  logic [IDX_W-1:0]          rd_idx;
  acc_e                      access;
  logic [N_LATCH*DATA_W-1:0] held_all;

  assign ctrl_raw = {rd_mode, half_sel, stb_cd_n, stb_ab_n};

  qlb_sync #(
    .WIDTH   (CTRL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTRL_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctrl_raw),
    .d_sync  (ctrl_s)
  );

  assign s_ab_n   = ctrl_s[0];
  assign s_cd_n   = ctrl_s[1];
  assign s_member = ctrl_s[2];
  assign s_rd     = ctrl_s[3];

  qlb_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_ab_n (s_ab_n),
    .stb_cd_n (s_cd_n),
    .member   (s_member),
    .rd       (s_rd),
    .wr_mask  (wr_mask),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .access   (access)
  );

  generate
    for (genvar i = 0; i < N_LATCH; i++) begin : g_cell
      qlb_cell #(.DATA_W(DATA_W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_mask[i]),
        .d     (bus_in),
        .held  (held_all[i*DATA_W +: DATA_W]),
        .code  (codes[i*DATA_W +: DATA_W])
      );

      // R3: an active write makes the channel follow the bus
      p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask[i] |-> codes[i*DATA_W +: DATA_W] == bus_in);
    end
  endgenerate

  qlb_readback #(.DATA_W(DATA_W)) u_readback (
    .clk      (clk),
    .rst_n    (rst_n),
    .held_all (held_all),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

  // R6: the driver is on only for a single-strobe read
  p_oe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (s_rd && (s_ab_n != s_cd_n) && access == ACC_READ));

  // R8: with both strobes high nothing is driven and no code moves
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ab_n && s_cd_n && $past(s_ab_n && s_cd_n)) |-> (!bus_oe && $stable(codes)));

endmodule

// File: tb/qlb_bank_bench.sv
module qlb_bank_bench;

  localparam time CLK_P    = 10ns;
  localparam int  DW       = 8;
  localparam int  NL       = 4;
  localparam int  SETUP_C  = 4;   // 40 ns bus/control setup before the strobe
  localparam int  WR_LOW_C = 20;  // 200 ns minimum write strobe
  localparam int  RD_LOW_C = 32;  // 320 ns minimum read strobe
  localparam int  GAP_C    = 12;  // 120 ns between strobe pulses
  localparam int  WDOG_C   = 190000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            stb_ab_n, stb_cd_n, half_sel, rd_mode;
  logic [DW-1:0]   bus_in;
  logic [DW-1:0]   bus_out;
  logic            bus_oe;
  logic [NL*DW-1:0] codes;

  logic [DW-1:0]   ref_mem [NL];
  int              n_chk = 0;
  int              n_err = 0;
  bit              done  = 0;

  always #(CLK_P/2) clk = ~clk;

  qlb_bank #(.DATA_W(DW), .SYNC_STAGES(2)) u_qlb_bank (
    .clk(clk), .rst_n(rst_n), .stb_ab_n(stb_ab_n), .stb_cd_n(stb_cd_n),
    .half_sel(half_sel), .rd_mode(rd_mode), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .codes(codes)
  );

  function automatic logic [NL*DW-1:0] pack_ref();
    logic [NL*DW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*DW +: DW] = ref_mem[i];
    return v;
  endfunction

  // latch number from strobe group and member, computed as group*2+member
  function automatic int idx_of(input int grp, input logic mem);
    return grp * 2 + int'(mem);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    stb_ab_n = 1'b1; stb_cd_n = 1'b1;
  endtask

  // write: gab/gcd select strobes, data first, then a mid-write change to ~data
  task automatic do_write(input bit gab, input bit gcd, input logic mem,
                          input logic [DW-1:0] data, input string req);
    logic [NL*DW-1:0] exp;
    logic [DW-1:0]    tmp [NL];
    @(negedge clk);
    rd_mode = 1'b0; half_sel = mem; bus_in = data;
    repeat (SETUP_C) @(negedge clk);
    stb_ab_n = ~gab; stb_cd_n = ~gcd;
    repeat (WR_LOW_C/2) @(negedge clk);
    for (int i = 0; i < NL; i++) tmp[i] = ref_mem[i];
    if (gab) tmp[idx_of(0, mem)] = data;
    if (gcd) tmp[idx_of(1, mem)] = data;
    for (int i = 0; i < NL; i++) exp[i*DW +: DW] = tmp[i];
    chk({req, "/R3 follow"}, 64'(codes), 64'(exp));
    bus_in = ~data;
    @(negedge clk);
    if (gab) tmp[idx_of(0, mem)] = ~data;
    if (gcd) tmp[idx_of(1, mem)] = ~data;
    for (int i = 0; i < NL; i++) exp[i*DW +: DW] = tmp[i];
    chk({req, "/R3 midchange"}, 64'(codes), 64'(exp));
    repeat (WR_LOW_C/2) @(negedge clk);
    go_idle();
    repeat (GAP_C) @(negedge clk);
    for (int i = 0; i < NL; i++) ref_mem[i] = tmp[i];
    chk({req, " stored"}, 64'(codes), 64'(pack_ref()));
    bus_in = data ^ 8'h3C;
    repeat (3) @(negedge clk);
    chk("R4 bus ignored after write", 64'(codes), 64'(pack_ref()));
  endtask

  task automatic do_read(input bit gab, input bit gcd, input logic mem);
    @(negedge clk);
    rd_mode = 1'b1; half_sel = mem; bus_in = 8'hC3;
    repeat (SETUP_C) @(negedge clk);
    stb_ab_n = ~gab; stb_cd_n = ~gcd;
    repeat (RD_LOW_C) @(negedge clk);
    if (gab ^ gcd) begin
      chk("R6 oe", 64'(bus_oe), 64'(1));
      chk("R6 data", 64'(bus_out), 64'(ref_mem[idx_of(gcd ? 1 : 0, mem)]));
    end else begin
      chk("R7 oe", 64'(bus_oe), 64'(0));
      chk("R7 codes", 64'(codes), 64'(pack_ref()));
    end
    go_idle();
    repeat (GAP_C) @(negedge clk);
    chk("R10 oe off", 64'(bus_oe), 64'(0));
    chk("R10 zero", 64'(bus_out), 64'(0));
  endtask

  initial begin
    rst_n = 1'b0; go_idle(); half_sel = 1'b0; rd_mode = 1'b0; bus_in = 8'h00;
    for (int i = 0; i < NL; i++) ref_mem[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 codes in reset", 64'(codes), 64'(0));
    chk("R1 oe in reset", 64'(bus_oe), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 codes after reset", 64'(codes), 64'(0));
    chk("R1 out after reset", 64'(bus_out), 64'(0));

    // R9: strobe visible only after two edges
    rd_mode = 1'b0; half_sel = 1'b0; bus_in = 8'h5A;
    repeat (SETUP_C) @(negedge clk);
    stb_ab_n = 1'b0;
    @(negedge clk);
    chk("R9 one edge", 64'(codes[7:0]), 64'(8'h00));
    @(negedge clk);
    chk("R9 two edges", 64'(codes[7:0]), 64'(8'h5A));
    repeat (WR_LOW_C) @(negedge clk);
    go_idle();
    repeat (GAP_C) @(negedge clk);
    ref_mem[0] = 8'h5A;
    chk("R9 stored", 64'(codes), 64'(pack_ref()));

    // R2/R6 sweep: every code through the four latches, each read back
    for (int k = 0; k < 256; k++) begin
      automatic int  tgt = k % NL;
      automatic bit  grp = (tgt >= 2);
      automatic logic mem = tgt[0];
      do_write(!grp, grp, mem, DW'(k) ^ 8'hA5, "R2 single");
      do_read(!grp, grp, mem);
    end

    // R5: dual writes, both pairs, then all four read back
    for (int m = 0; m < 2; m++) begin
      do_write(1'b1, 1'b1, m[0], 8'h96 + DW'(m), "R5 dual");
      for (int t = 0; t < NL; t++) do_read(t < 2, t >= 2, t[0]);
    end

    // R7: dual read leaves everything alone
    do_read(1'b1, 1'b1, 1'b0);
    do_read(1'b1, 1'b1, 1'b1);

    // R8: hold under every member/direction value with a moving bus
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      half_sel = p[0]; rd_mode = p[1]; bus_in = DW'(p * 8'h37 + 1);
      go_idle();
      repeat (4) @(negedge clk);
      chk("R8 hold codes", 64'(codes), 64'(pack_ref()));
      chk("R8 hold oe", 64'(bus_oe), 64'(0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG_C) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule